// File: doc/BRIEF.md
# Time-Division Slot-Table Flit Injector

This block sits at the sending side of a network interface. Each connection writes data words into its own queue. A small slot table decides, one slot at a time, which connection may inject a fixed-size flit into the network. A slot lasts exactly one flit cycle of three clocks. The table entry for the current slot names the owning connection. At the first clock of the slot, the block checks whether that connection's queue holds a full flit payload. If it does, the block emits a header word followed by two payload words, one word per clock.

The schedule does not share spare capacity. A slot whose owner has too little data stays idle, even when other queues are full. This keeps each connection's timing independent of the others: no two flits can meet downstream, because the table alone decides who injects and when. Software edits a shadow copy of the table at any time. The shadow copy becomes active only when the slot counter wraps, so a flit already on the wire is never cut short. The forwarding path of each connection comes from a per-connection route input, and it is placed in every header word.

Top module: `tdm_injector`

## Requirements
- R1: After reset, every table entry is empty and `flitValid` and `flitStart` stay low until a programmed entry has been committed and its owner has data.
- R2: A word counter runs 0,1,2 on every clock from reset. The slot counter starts at 0, advances after word 2, and wraps from slot 3 to slot 0.
- R3: A granted flit is three consecutive clocks with `flitValid` high. `flitStart` is high only on the first of the three.
- R4: The header word holds the connection's route in bits [7:0] and the connection index in bits [9:8]. Bits [15:10] are zero.
- R5: The two payload words are the owner's oldest two queued words, in write order, and both are removed from its queue.
- R6: A slot is granted only at word 0, and only when the active entry is valid and its owner's queue holds at least two words. Otherwise the slot is idle and no other connection uses it.
- R7: A table write changes only the shadow entry. All shadow entries are copied to the active table at the clock edge that ends word 2 of slot 3. A write made on that same edge becomes active at the next wrap.
- R8: One connection may own several slots and is served in each of them.
- R9: Each queue holds four words, and `inReady[c]` is high exactly when queue c is not full. A write to a full queue is dropped and never appears in any flit.
- R10: A table write with the valid bit clear, or with a connection index of 3 or more, makes that slot empty once committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWrEn | input | 3 | Per-connection queue write strobe |
| inData | input | 48 | Per-connection write data, connection c in bits [16c+15:16c] |
| inReady | output | 3 | Per-connection queue not full |
| routeCfg | input | 24 | Per-connection route, connection c in bits [8c+7:8c] |
| tblWrEn | input | 1 | Shadow table write strobe |
| tblWrIdx | input | 2 | Slot index to write |
| tblWrValid | input | 1 | Entry owns its slot when set |
| tblWrConn | input | 2 | Owning connection index |
| flitValid | output | 1 | Flit word valid |
| flitStart | output | 1 | Marks the header word of a flit |
| flitData | output | 16 | Flit word; zero when not valid |

## Verification
The bench uses the default build: three connections, four slots, three-word flits and four-word queues. At this size one connection can own two slots while another has a partial payload and a third has no slot at all, so slot starvation and idle slots both occur. Four-word queues fill in a few writes, which makes the dropped-write case reachable. A table rewrite made mid-round shows whether the change waits for the wrap.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  parameter int CONN_NUM = 3;
  parameter int SLOT_NUM = 4;
  parameter int FLIT_LEN = 3;
  parameter int DATA_W   = 16;
  parameter int ROUTE_W  = 8;
  parameter int Q_DEPTH  = 4;

  localparam int CONN_W  = $clog2(CONN_NUM);
  localparam int SLOT_W  = $clog2(SLOT_NUM);
  localparam int WORD_W  = $clog2(FLIT_LEN);
  localparam int PTR_W   = $clog2(Q_DEPTH);
  localparam int CNT_W   = $clog2(Q_DEPTH + 1);
  localparam int PAY_LEN = FLIT_LEN - 1;

  typedef struct packed {
    logic              valid;
    logic [CONN_W-1:0] conn;
  } slotEntry_t;

  typedef struct packed {
    logic              sendHdr;
    logic              sendPay;
    logic [CONN_W-1:0] conn;
  } strobe_t;
endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tblWrEn,
  input  logic [SLOT_W-1:0]   tblWrIdx,
  input  logic                tblWrValid,
  input  logic [CONN_W-1:0]   tblWrConn,
  input  logic [CONN_NUM-1:0] hasFlit,
  output strobe_t             strobe
);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(FLIT_LEN - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_NUM - 1);

  logic [WORD_W-1:0] wordCnt;
  logic [SLOT_W-1:0] slotCnt;
  slotEntry_t        shadowTbl [SLOT_NUM];
  slotEntry_t        activeTbl [SLOT_NUM];
  logic              sending;
  logic [CONN_W-1:0] sendConn;

  logic       lastWord, wrap, grant, ownerOk;
  slotEntry_t curEntry;

  always_comb begin
    lastWord = (wordCnt == WORD_LAST);
    wrap     = lastWord && (slotCnt == SLOT_LAST);
    curEntry = activeTbl[slotCnt];
    ownerOk  = curEntry.valid && (int'(curEntry.conn) < CONN_NUM);
    grant    = (wordCnt == '0) && ownerOk && hasFlit[curEntry.conn];
    strobe.sendHdr = grant;
    strobe.sendPay = sending && (wordCnt != '0);
    strobe.conn    = grant ? curEntry.conn : sendConn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt  <= '0;
      slotCnt  <= '0;
      sending  <= 1'b0;
      sendConn <= '0;
    end else begin
      wordCnt <= lastWord ? '0 : wordCnt + 1'b1;
      if (lastWord) slotCnt <= wrap ? '0 : slotCnt + 1'b1;
      if (grant) begin
        sending  <= 1'b1;
        sendConn <= curEntry.conn;
      end else if (lastWord) begin
        sending <= 1'b0;
      end
    end
  end

  // shadow written any time; active copy refreshed only at the wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOT_NUM; i++) begin
        shadowTbl[i] <= '0;
        activeTbl[i] <= '0;
      end
    end else begin
      if (wrap)
        for (int i = 0; i < SLOT_NUM; i++) activeTbl[i] <= shadowTbl[i];
      if (tblWrEn) shadowTbl[tblWrIdx] <= '{valid: tblWrValid, conn: tblWrConn};
    end
  end

  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (slotCnt == '0) && (wordCnt == '0));
  p_table_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> (activeTbl[0] == $past(activeTbl[0])) && (activeTbl[SLOT_NUM-1] == $past(activeTbl[SLOT_NUM-1])));
  p_hdr_then_pay_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendHdr |=> strobe.sendPay && !strobe.sendHdr && (strobe.conn == $past(strobe.conn)));
  p_grant_word0_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendHdr |-> $past(lastWord) || $past(!rstN));
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CONN_NUM-1:0]          inWrEn,
  input  logic [CONN_NUM*DATA_W-1:0]   inData,
  input  logic [CONN_NUM*ROUTE_W-1:0]  routeCfg,
  input  strobe_t                      strobe,
  output logic [CONN_NUM-1:0]          inReady,
  output logic [CONN_NUM-1:0]          hasFlit,
  output logic                         flitValid,
  output logic                         flitStart,
  output logic [DATA_W-1:0]            flitData
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(Q_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(Q_DEPTH);
  localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(PAY_LEN);

  logic [DATA_W-1:0] headWord [CONN_NUM];
  logic [DATA_W-1:0] hdrWord  [CONN_NUM];

  for (genvar c = 0; c < CONN_NUM; c++) begin : g_queue
    logic [DATA_W-1:0] mem [Q_DEPTH];
    logic [PTR_W-1:0]  rdPtr, wrPtr;
    logic [CNT_W-1:0]  count;
    logic              push, pop;

    assign inReady[c]  = (count != CNT_FULL);
    assign hasFlit[c]  = (count >= CNT_PAY);
    assign push        = inWrEn[c] && inReady[c];
    assign pop         = strobe.sendPay && (int'(strobe.conn) == c);
    assign headWord[c] = mem[rdPtr];
    assign hdrWord[c]  = DATA_W'({CONN_W'(c), routeCfg[c*ROUTE_W +: ROUTE_W]});

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (push) begin
          mem[wrPtr] <= inData[c*DATA_W +: DATA_W];
          wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
        end
        if (pop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
        count <= count + CNT_W'(push) - CNT_W'(pop);
      end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
      count <= CNT_FULL);
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rstN)
      pop |-> count != '0);
  end

  always_comb begin
    flitValid = strobe.sendHdr || strobe.sendPay;
    flitStart = strobe.sendHdr;
    if (strobe.sendHdr)      flitData = hdrWord[strobe.conn];
    else if (strobe.sendPay) flitData = headWord[strobe.conn];
    else                     flitData = '0;
  end
endmodule

// File: rtl/tdm_injector.sv
module tdm_injector
  import tdm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CONN_NUM-1:0]          inWrEn,
  input  logic [CONN_NUM*DATA_W-1:0]   inData,
  output logic [CONN_NUM-1:0]          inReady,
  input  logic [CONN_NUM*ROUTE_W-1:0]  routeCfg,
  input  logic                         tblWrEn,
  input  logic [SLOT_W-1:0]            tblWrIdx,
  input  logic                         tblWrValid,
  input  logic [CONN_W-1:0]            tblWrConn,
  output logic                         flitValid,
  output logic                         flitStart,
  output logic [DATA_W-1:0]            flitData
);
  strobe_t             strobe;
  logic [CONN_NUM-1:0] hasFlit;

  tdm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrValid(tblWrValid), .tblWrConn(tblWrConn), .hasFlit(hasFlit),
    .strobe(strobe)
  );

  tdm_datapath u_dp (
    .clk(clk), .rstN(rstN), .inWrEn(inWrEn), .inData(inData),
    .routeCfg(routeCfg), .strobe(strobe), .inReady(inReady),
    .hasFlit(hasFlit), .flitValid(flitValid), .flitStart(flitStart),
    .flitData(flitData)
  );

  p_start_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    flitStart |-> flitValid ##1 (flitValid && !flitStart) ##1 (flitValid && !flitStart));
endmodule

// File: tb/tdm_injector_tb_top.sv
module tdm_injector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, DW = 16, RW = 8, DEPTH = 4;

  logic          clk = 0;
  logic          rstN = 0;
  logic [NC-1:0] inWrEn = '0;
  logic [NC*DW-1:0] inData = '0;
  logic [NC-1:0] inReady;
  logic [NC*RW-1:0] routeCfg = {8'hC3, 8'h5A, 8'h17};
  logic          tblWrEn = 0, tblWrValid = 0;
  logic [1:0]    tblWrIdx = '0, tblWrConn = '0;
  logic          flitValid, flitStart;
  logic [DW-1:0] flitData;

  int checks = 0, errors = 0, hdrSeen = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] mq [NC][$];
  logic [2:0] mShadow [4];
  logic [2:0] mActive [4];
  int  mWord = 0, mSlot = 0, mSendConn = 0;
  bit  mSending = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_injector dut_i (
    .clk(clk), .rstN(rstN), .inWrEn(inWrEn), .inData(inData), .inReady(inReady),
    .routeCfg(routeCfg), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrValid(tblWrValid), .tblWrConn(tblWrConn),
    .flitValid(flitValid), .flitStart(flitStart), .flitData(flitData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor/scoreboard: compare outputs, then advance the model one edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int  oc;
      bit  g, pay;
      bit  full [NC];
      logic [DW-1:0] expData;
      oc  = int'(mActive[mSlot][1:0]);
      g   = (mWord == 0) && mActive[mSlot][2] && (oc < NC) && (mq[oc].size() >= 2); // R6 R10
      pay = mSending && (mWord != 0);
      if (g) expData = DW'({2'(oc), routeCfg[oc*RW +: RW]});           // R4
      else if (pay) expData = mq[mSendConn][0];                         // R5
      else expData = '0;
      check("R3/R6 valid", flitValid, g || pay);
      check("R3 start", flitStart, g);
      check(g ? "R4 header" : "R5 payload", flitData, expData);
      if (g) hdrSeen++;
      for (int c = 0; c < NC; c++) begin
        full[c] = (mq[c].size() == DEPTH);
        check("R9 ready", inReady[c], !full[c]);
      end
      if (pay) void'(mq[mSendConn].pop_front());
      for (int c = 0; c < NC; c++)
        if (inWrEn[c] && !full[c]) mq[c].push_back(inData[c*DW +: DW]);
      if (mWord == 2 && mSlot == 3)
        for (int s = 0; s < 4; s++) mActive[s] = mShadow[s];           // R7
      if (tblWrEn) mShadow[tblWrIdx] = {tblWrValid, tblWrConn};
      if (g) begin mSending = 1; mSendConn = oc; end
      else if (mWord == 2) mSending = 0;
      if (mWord == 2) begin mWord = 0; mSlot = (mSlot + 1) % 4; end  // R2
      else mWord++;
    end
  end

  task automatic push(input int c, input logic [DW-1:0] d);
    @(posedge clk); #1;
    inWrEn = '0; inWrEn[c] = 1'b1; inData[c*DW +: DW] = d;
    @(posedge clk); #1;
    inWrEn = '0;
  endtask

  task automatic tblWrite(input int idx, input bit v, input int conn);
    @(posedge clk); #1;
    tblWrEn = 1; tblWrIdx = 2'(idx); tblWrValid = v; tblWrConn = 2'(conn);
    @(posedge clk); #1;
    tblWrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin mShadow[s] = '0; mActive[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", flitValid, 1'b0);
    check("R1 reset start", flitStart, 1'b0);
    @(posedge clk); #1; rstN = 1;
    // R1: data queued but no table committed yet
    push(0, 16'h1001); push(0, 16'h1002);
    idle(10);
    // R8: conn0 owns slots 0 and 2; R10: slot1 empty; conn1 on slot3
    tblWrite(0, 1, 0); tblWrite(2, 1, 0); tblWrite(3, 1, 1); tblWrite(1, 0, 2);
    push(0, 16'h1003); push(0, 16'h1004);
    push(1, 16'h2001);                         // R6: one word only, slot3 idle
    push(2, 16'h3001); push(2, 16'h3002);      // no slot owned
    idle(40);
    push(1, 16'h2002);                         // now conn1 can send
    idle(30);
    // R9: overfill conn2 while it has no slot
    push(2, 16'h3003); push(2, 16'h3004); push(2, 16'h3005);
    // R7: mid-round rewrite gives slot1 to conn2, effective at wrap
    tblWrite(1, 1, 2);
    idle(40);
    // R10: out-of-range owner empties a slot; conn0 refill
    tblWrite(0, 1, 3);
    push(0, 16'h1005); push(0, 16'h1006); push(0, 16'h1007); push(0, 16'h1008);
    idle(60);
    done = 1;
    check("R8 flits emitted", (hdrSeen >= 6), 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule